// File: doc/BRIEF.md
# Flash Memory Command Controller

This block runs a small set of coded commands against an embedded nonvolatile word array. The array is modelled as registers inside the block. A host reaches five registers through a simple word bus. It loads an address, a data word and a mode word, and then writes a command code. The controller holds a busy flag for a programmable number of clock cycles, which stands in for the program or erase time. It commits the memory effect in the last busy cycle and then reports the outcome in a status register.

Status flags are sticky. Reading the status register clears all of them except busy. A completion interrupt can be enabled through the mode register, and it is driven out on its own pin. Commands that alter the array run only when a software protection bit is set. The whole-array erase also needs a two-word unlock key, and it always spares a low kernel region of the array.

Top module: `flashctl_top`

## Requirements
- R1: After reset, the command, address, data, mode and status registers read 0, `irq` is low, and every array word holds 0xFFFF.
- R2: The register offsets are 0 command, 1 address, 2 data, 3 mode and 4 status; offsets 5 to 7 read 0. Status bit 0 is complete, bit 1 is fail, bit 2 is busy and bit 3 is interrupt; bits 15:4 read 0. Mode bit 3 enables altering commands and mode bit 4 enables the interrupt.
- R3: Code 0x01 loads the data register from the array word at the address register. Code 0x02 stores the data register into that word.
- R4: After an executed command, busy reads 1 for exactly the configured cycle count: WRITE_CYC for 0x02, ERASEWR_CYC for 0x03, ERASE_CYC for 0x05, MASS_CYC for 0x06, and 1 for 0x01, 0x04 and 0x0F. When busy falls, complete is set.
- R5: Code 0x04 compares the addressed word with the data register. A mismatch sets fail together with complete; a match sets complete only.
- R6: Code 0x05 sets every word of the PAGE_WORDS-aligned page that holds the address to 0xFFFF. Code 0x03 does the same and then writes the data register at the address.
- R7: With mode bit 3 clear, codes 0x02, 0x03, 0x05 and 0x06 are refused. Fail and complete set on the next clock edge, busy never rises, and the array is unchanged.
- R8: Any code other than 0x00 to 0x06 and 0x0F is refused in the same way as R7.
- R9: Code 0x06 runs only if the last two bus writes before it were KEY_A and then KEY_B to the data register; otherwise it is refused. When it runs, it sets every word at or above KERNEL_WORDS to 0xFFFF and leaves the words below untouched.
- R10: Reading the status register clears its bits 3, 1 and 0 on that clock edge. A flag that sets on the same edge wins.
- R11: Code 0x0F changes no memory but completes. Status bit 3, mirrored on `irq`, sets at completion or refusal only when mode bit 4 is set.
- R12: A command write while busy is ignored. The command register keeps the running code, and no extra busy time follows.
- R13: The command register reads 0x07 once a command completes or is refused. Writing 0x00 stores 0x00 and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (clears status flags on a status read) |
| busAddr | input | 3 | Register offset |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from busAddr |
| irq | output | 1 | Completion interrupt, equal to status bit 3 |

## Verification
The bench builds the block with a 64-word array, 8-word pages, a 16-word kernel and operation times of 3, 5, 6 and 8 cycles. With these values, every busy window can be counted cycle by cycle, and a mass erase finishes quickly. A page erase at word 22 is seen to clear word 21 but not word 30. The kernel border at word 16 lies inside the small array, so one mass erase shows a kernel word kept and a user word cleared.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;

  localparam logic [2:0] REG_CMD    = 3'd0;
  localparam logic [2:0] REG_ADDR   = 3'd1;
  localparam logic [2:0] REG_DATA   = 3'd2;
  localparam logic [2:0] REG_MODE   = 3'd3;
  localparam logic [2:0] REG_STATUS = 3'd4;

  localparam logic [7:0] CMD_NULL        = 8'h00;
  localparam logic [7:0] CMD_READ        = 8'h01;
  localparam logic [7:0] CMD_WRITE       = 8'h02;
  localparam logic [7:0] CMD_ERASE_WRITE = 8'h03;
  localparam logic [7:0] CMD_VERIFY      = 8'h04;
  localparam logic [7:0] CMD_PAGE_ERASE  = 8'h05;
  localparam logic [7:0] CMD_MASS_ERASE  = 8'h06;
  localparam logic [7:0] CMD_FINISHED    = 8'h07;
  localparam logic [7:0] CMD_PING        = 8'h0F;

  // Strobes from control to datapath.
  typedef struct packed {
    logic launch;       // latch operands at command start
    logic doRead;       // load data register from array
    logic doWrite;      // store operand word
    logic doPageErase;  // erase operand page
    logic doMassErase;  // erase all user words
  } dpStrobe_t;

  function automatic logic isKnownCode(input logic [7:0] c);
    return (c == CMD_READ) || (c == CMD_WRITE) || (c == CMD_ERASE_WRITE) ||
           (c == CMD_VERIFY) || (c == CMD_PAGE_ERASE) || (c == CMD_MASS_ERASE) ||
           (c == CMD_PING);
  endfunction

  function automatic logic isAlteringCode(input logic [7:0] c);
    return (c == CMD_WRITE) || (c == CMD_ERASE_WRITE) ||
           (c == CMD_PAGE_ERASE) || (c == CMD_MASS_ERASE);
  endfunction

endpackage

// File: rtl/flashctl_ctrl.sv
module flashctl_ctrl
  import flashctl_pkg::*;
#(
  parameter int WRITE_CYC   = 50,
  parameter int ERASE_CYC   = 300,
  parameter int ERASEWR_CYC = 400,
  parameter int MASS_CYC    = 2000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdWr,
  input  logic [7:0] cmdData,
  input  logic      statRd,
  input  logic      wrEnable,
  input  logic      intEnable,
  input  logic      keyArmed,
  input  logic      mismatch,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic [3:0] statusBits,
  output logic [7:0] cmdValue
);

  localparam int MAX_A   = (WRITE_CYC > ERASE_CYC) ? WRITE_CYC : ERASE_CYC;
  localparam int MAX_B   = (ERASEWR_CYC > MASS_CYC) ? ERASEWR_CYC : MASS_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic [7:0]       opCode;
  logic             doneFlag, failFlag, intFlag;
  logic             idleCmd, accept, launchNow, refuseNow, finishNow;

  function automatic logic [CNT_W-1:0] durOf(input logic [7:0] c);
    case (c)
      CMD_WRITE:       return CNT_W'(WRITE_CYC - 1);
      CMD_ERASE_WRITE: return CNT_W'(ERASEWR_CYC - 1);
      CMD_PAGE_ERASE:  return CNT_W'(ERASE_CYC - 1);
      CMD_MASS_ERASE:  return CNT_W'(MASS_CYC - 1);
      default:         return '0;
    endcase
  endfunction

  always_comb begin
    idleCmd   = cmdWr && !busy;
    accept    = isKnownCode(cmdData) &&
                (!isAlteringCode(cmdData) || wrEnable) &&
                ((cmdData != CMD_MASS_ERASE) || keyArmed);
    launchNow = idleCmd && accept;
    refuseNow = idleCmd && !accept && (cmdData != CMD_NULL);
    finishNow = busy && (cnt == '0);
  end

  always_comb begin
    strobe.launch      = launchNow;
    strobe.doRead      = finishNow && (opCode == CMD_READ);
    strobe.doWrite     = finishNow && ((opCode == CMD_WRITE) || (opCode == CMD_ERASE_WRITE));
    strobe.doPageErase = finishNow && ((opCode == CMD_PAGE_ERASE) || (opCode == CMD_ERASE_WRITE));
    strobe.doMassErase = finishNow && (opCode == CMD_MASS_ERASE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cnt      <= '0;
      opCode   <= CMD_NULL;
      cmdValue <= CMD_NULL;
      doneFlag <= 1'b0;
      failFlag <= 1'b0;
      intFlag  <= 1'b0;
    end else begin
      // Read-clear first; any set below overrides it.
      if (statRd) begin
        doneFlag <= 1'b0;
        failFlag <= 1'b0;
        intFlag  <= 1'b0;
      end
      if (idleCmd) begin
        cmdValue <= cmdData;
        if (launchNow) begin
          busy   <= 1'b1;
          cnt    <= durOf(cmdData);
          opCode <= cmdData;
        end else if (refuseNow) begin
          cmdValue <= CMD_FINISHED;
          doneFlag <= 1'b1;
          failFlag <= 1'b1;
          if (intEnable) intFlag <= 1'b1;
        end
      end else if (busy) begin
        if (finishNow) begin
          busy     <= 1'b0;
          cmdValue <= CMD_FINISHED;
          doneFlag <= 1'b1;
          if ((opCode == CMD_VERIFY) && mismatch) failFlag <= 1'b1;
          if (intEnable) intFlag <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign statusBits = {intFlag, busy, failFlag, doneFlag};

endmodule

// File: rtl/flashctl_dp.sv
module flashctl_dp
  import flashctl_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          PAGE_WORDS   = 16,
  parameter int          KERNEL_WORDS = 32,
  parameter logic [15:0] KEY_A        = 16'h5A3C,
  parameter logic [15:0] KEY_B        = 16'hC3A5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [2:0]  busAddr,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  input  dpStrobe_t   strobe,
  input  logic [3:0]  statusBits,
  input  logic [7:0]  cmdValue,
  output logic        wrEnable,
  output logic        intEnable,
  output logic        keyArmed,
  output logic        mismatch
);

  localparam int WORDS = 1 << ADDR_W;
  localparam int PG_W  = $clog2(PAGE_WORDS);

  logic [15:0]       mem [WORDS];
  logic [ADDR_W-1:0] addrReg, opAddr;
  logic [15:0]       dataReg, opData;
  logic [7:0]        modeReg;
  logic              keyHalf;
  int                opPage;

  assign opPage    = int'(opAddr >> PG_W);
  assign mismatch  = (mem[opAddr] != opData);
  assign wrEnable  = modeReg[3];
  assign intEnable = modeReg[4];

  // Host registers, operand latch and unlock key tracking.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      dataReg  <= '0;
      modeReg  <= '0;
      opAddr   <= '0;
      opData   <= '0;
      keyHalf  <= 1'b0;
      keyArmed <= 1'b0;
    end else begin
      if (busWr) begin
        case (busAddr)
          REG_ADDR: addrReg <= busWdata[ADDR_W-1:0];
          REG_DATA: dataReg <= busWdata;
          REG_MODE: modeReg <= busWdata[7:0];
          default: ;
        endcase
        if (busAddr == REG_DATA) begin
          keyHalf  <= (busWdata == KEY_A);
          keyArmed <= keyHalf && (busWdata == KEY_B);
        end else begin
          keyHalf  <= 1'b0;
          keyArmed <= 1'b0;
        end
      end
      if (strobe.launch) begin
        opAddr <= addrReg;
        opData <= dataReg;
      end
      if (strobe.doRead) dataReg <= mem[opAddr];
    end
  end

  // Array: erases first, a word write after them wins.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (strobe.doMassErase && (i >= KERNEL_WORDS)) mem[i] <= 16'hFFFF;
        if (strobe.doPageErase && ((i >> PG_W) == opPage)) mem[i] <= 16'hFFFF;
      end
      if (strobe.doWrite) mem[opAddr] <= opData;
    end
  end

  always_comb begin
    case (busAddr)
      REG_CMD:    busRdata = {8'h00, cmdValue};
      REG_ADDR:   busRdata = 16'(addrReg);
      REG_DATA:   busRdata = dataReg;
      REG_MODE:   busRdata = {8'h00, modeReg};
      REG_STATUS: busRdata = {12'h000, statusBits};
      default:    busRdata = 16'h0000;
    endcase
  end

endmodule

// File: rtl/flashctl_top.sv
module flashctl_top
  import flashctl_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          PAGE_WORDS   = 16,
  parameter int          KERNEL_WORDS = 32,
  parameter int          WRITE_CYC    = 50,
  parameter int          ERASE_CYC    = 300,
  parameter int          ERASEWR_CYC  = 400,
  parameter int          MASS_CYC     = 2000,
  parameter logic [15:0] KEY_A        = 16'h5A3C,
  parameter logic [15:0] KEY_B        = 16'hC3A5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [2:0]  busAddr,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic        irq
);

  dpStrobe_t  strobe;
  logic       busy, wrEnable, intEnable, keyArmed, mismatch;
  logic [3:0] statusBits;
  logic [7:0] cmdValue;
  logic       cmdWr, statRd;

  assign cmdWr  = busWr && (busAddr == REG_CMD);
  assign statRd = busRd && (busAddr == REG_STATUS);
  assign irq    = statusBits[3];

  flashctl_ctrl #(
    .WRITE_CYC(WRITE_CYC), .ERASE_CYC(ERASE_CYC),
    .ERASEWR_CYC(ERASEWR_CYC), .MASS_CYC(MASS_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(busWdata[7:0]),
    .statRd(statRd), .wrEnable(wrEnable), .intEnable(intEnable),
    .keyArmed(keyArmed), .mismatch(mismatch), .strobe(strobe),
    .busy(busy), .statusBits(statusBits), .cmdValue(cmdValue)
  );

  flashctl_dp #(
    .ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS), .KERNEL_WORDS(KERNEL_WORDS),
    .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) dp_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .strobe(strobe),
    .statusBits(statusBits), .cmdValue(cmdValue), .wrEnable(wrEnable),
    .intEnable(intEnable), .keyArmed(keyArmed), .mismatch(mismatch)
  );

endmodule

// File: rtl/flashctl_chk.sv
module flashctl_chk
  import flashctl_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busWr,
  input logic        busRd,
  input logic [2:0]  busAddr,
  input logic [15:0] busWdata,
  input logic [3:0]  statusBits,
  input logic [7:0]  cmdValue,
  input logic        intEnable
);

  logic cmdWrSeen, statRdSeen, busyNow, reservedCode;
  assign cmdWrSeen    = busWr && (busAddr == REG_CMD);
  assign statRdSeen   = busRd && (busAddr == REG_STATUS);
  assign busyNow      = statusBits[2];
  assign reservedCode = !isKnownCode(busWdata[7:0]) && (busWdata[7:0] != CMD_NULL);

  p_busy_from_cmd_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyNow) |-> $past(cmdWrSeen));

  p_reserved_refused_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrSeen && !busyNow && reservedCode) |=>
      (!statusBits[2] && statusBits[1] && statusBits[0]));

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (statRdSeen && !busyNow && !cmdWrSeen) |=>
      (statusBits[3] == 1'b0 && statusBits[1] == 1'b0 && statusBits[0] == 1'b0));

  p_int_needs_enable_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBits[3]) |-> $past(intEnable));

  p_busy_ignores_cmd_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busyNow && cmdWrSeen) |=>
      (cmdValue == CMD_FINISHED || cmdValue == $past(cmdValue)));

  p_finish_readback_r13: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyNow) |-> (cmdValue == CMD_FINISHED && statusBits[0]));

endmodule

bind flashctl_top flashctl_chk chk_i (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
  .busWdata(busWdata), .statusBits(statusBits), .cmdValue(cmdValue),
  .intEnable(intEnable)
);

// File: tb/flashctl_tb.sv
`timescale 1ns/1ps
module flashctl_top_tb_top;

  localparam int          T_WRITE = 3;
  localparam int          T_ERASE = 5;
  localparam int          T_EWR   = 6;
  localparam int          T_MASS  = 8;
  localparam logic [15:0] KA      = 16'h5A3C;
  localparam logic [15:0] KB      = 16'hC3A5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [15:0] busWdata = 16'h0;
  logic [15:0] busRdata;
  logic        irq;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  flashctl_top #(
    .ADDR_W(6), .PAGE_WORDS(8), .KERNEL_WORDS(16),
    .WRITE_CYC(T_WRITE), .ERASE_CYC(T_ERASE), .ERASEWR_CYC(T_EWR), .MASS_CYC(T_MASS),
    .KEY_A(KA), .KEY_B(KB)
  ) dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  typedef struct packed {
    logic [7:0]  mode;
    logic [7:0]  code;
    logic [15:0] addr;
    logic [15:0] data;
    logic [3:0]  stat;
    logic [15:0] rdData;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'h08, 8'h02, 16'd20, 16'h1234, 4'h1, 16'h1234},
    '{8'h08, 8'h01, 16'd20, 16'h0000, 4'h1, 16'h1234},
    '{8'h08, 8'h04, 16'd20, 16'h1234, 4'h1, 16'h1234},
    '{8'h08, 8'h04, 16'd20, 16'h1235, 4'h3, 16'h1235},
    '{8'h18, 8'h0F, 16'd0,  16'h0000, 4'h9, 16'h0000},
    '{8'h08, 8'h02, 16'd21, 16'hABCD, 4'h1, 16'hABCD},
    '{8'h08, 8'h05, 16'd22, 16'h0000, 4'h1, 16'h0000},
    '{8'h08, 8'h01, 16'd21, 16'h0000, 4'h1, 16'hFFFF},
    '{8'h08, 8'h03, 16'd17, 16'h5555, 4'h1, 16'h5555},
    '{8'h08, 8'h01, 16'd17, 16'h0000, 4'h1, 16'h5555},
    '{8'h08, 8'h01, 16'd20, 16'h0000, 4'h1, 16'hFFFF},
    '{8'h00, 8'h02, 16'd30, 16'h1111, 4'h3, 16'h1111},
    '{8'h08, 8'h01, 16'd30, 16'h0000, 4'h1, 16'hFFFF},
    '{8'h18, 8'h09, 16'd0,  16'h0000, 4'hB, 16'h0000},
    '{8'h08, 8'h0B, 16'd0,  16'h0000, 4'h3, 16'h0000},
    '{8'h00, 8'h05, 16'd16, 16'h0000, 4'h3, 16'h0000}
  };

  function automatic string tagOf(input vec_t v);
    if (v.code == 8'h09 || v.code == 8'h0B) return "R8";
    if (v.mode[3] == 1'b0) return "R7";
    case (v.code)
      8'h04:        return "R5";
      8'h03, 8'h05: return "R6";
      8'h0F:        return "R11";
      default:      return "R3";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Tasks start and end at a falling edge.
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    busRd = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic waitIdle(output logic [15:0] s, output int n);
    n = 0;
    do begin
      rd(3'd4, s);
      if (s[2]) n++;
    end while (s[2] && n < 5000);
  endtask

  task automatic runCmd(input logic [7:0] c, output logic [15:0] s, output int n);
    wr(3'd0, {8'h00, c});
    waitIdle(s, n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] s, d;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", {16'h0, d}, 32'h0);
    end
    chk("R1 irq low", {31'h0, irq}, 32'h0);

    // Vector table: R2 R3 R5 R6 R7 R8 R11
    for (int i = 0; i < NV; i++) begin
      wr(3'd3, {8'h00, VECS[i].mode});
      wr(3'd1, VECS[i].addr);
      wr(3'd2, VECS[i].data);
      runCmd(VECS[i].code, s, n);
      chk(tagOf(VECS[i]), {16'h0, s}, {28'h0, VECS[i].stat});
      rd(3'd2, d);
      chk(tagOf(VECS[i]), {16'h0, d}, {16'h0, VECS[i].rdData});
    end
    rd(3'd1, d);
    chk("R2 address readback", {16'h0, d}, 32'd16);

    // R4: busy windows
    wr(3'd3, 16'h0008); wr(3'd1, 16'd40); wr(3'd2, 16'h2222);
    runCmd(8'h02, s, n); chk("R4 write busy", n, T_WRITE);
    runCmd(8'h03, s, n); chk("R4 erase-write busy", n, T_EWR);
    runCmd(8'h05, s, n); chk("R4 page erase busy", n, T_ERASE);
    chk("R4 complete after busy", {16'h0, s}, 32'h1);
    runCmd(8'h01, s, n); chk("R4 read busy", n, 1);

    // R12: command while busy is ignored
    wr(3'd1, 16'd41); wr(3'd2, 16'h3333);
    wr(3'd0, 16'h0003);
    rd(3'd0, d); chk("R12 running code", {16'h0, d}, 32'h3);
    wr(3'd0, 16'h0002);
    rd(3'd0, d); chk("R12 code kept", {16'h0, d}, 32'h3);
    waitIdle(s, n);
    chk("R12 status", {16'h0, s}, 32'h1);
    rd(3'd4, s); chk("R12 no extra busy", {16'h0, s}, 32'h0);
    rd(3'd0, d); chk("R13 finished code", {16'h0, d}, 32'h7);

    // R13: null command
    wr(3'd0, 16'h0000);
    rd(3'd0, d); chk("R13 null stored", {16'h0, d}, 32'h0);
    rd(3'd4, s); chk("R13 null starts nothing", {16'h0, s}, 32'h0);

    // R11 / R10: interrupt and read-clear
    wr(3'd3, 16'h0018);
    wr(3'd0, 16'h000F);
    repeat (3) @(negedge clk);
    chk("R11 irq raised", {31'h0, irq}, 32'h1);
    rd(3'd4, s); chk("R11 status on ping", {16'h0, s}, 32'h9);
    chk("R10 irq cleared by read", {31'h0, irq}, 32'h0);
    rd(3'd4, s); chk("R10 status cleared", {16'h0, s}, 32'h0);
    wr(3'd3, 16'h0008);
    wr(3'd0, 16'h000F);
    repeat (3) @(negedge clk);
    chk("R11 irq gated", {31'h0, irq}, 32'h0);
    rd(3'd4, s); chk("R11 no int status", {16'h0, s}, 32'h1);

    // R9: mass erase and kernel
    wr(3'd1, 16'd3);  wr(3'd2, 16'h7777); runCmd(8'h02, s, n);
    wr(3'd1, 16'd40); wr(3'd2, 16'h8888); runCmd(8'h02, s, n);
    runCmd(8'h06, s, n); chk("R9 no key refused", {16'h0, s}, 32'h3);
    wr(3'd2, KA); wr(3'd1, 16'd40); wr(3'd2, KB);
    runCmd(8'h06, s, n); chk("R9 broken key refused", {16'h0, s}, 32'h3);
    wr(3'd3, 16'h0000); wr(3'd2, KA); wr(3'd2, KB);
    runCmd(8'h06, s, n); chk("R7 mass erase unprotected", {16'h0, s}, 32'h3);
    wr(3'd3, 16'h0008); wr(3'd2, KA); wr(3'd2, KB);
    runCmd(8'h06, s, n);
    chk("R9 mass status", {16'h0, s}, 32'h1);
    chk("R4 mass busy", n, T_MASS);
    wr(3'd1, 16'd3); runCmd(8'h01, s, n);
    rd(3'd2, d); chk("R9 kernel kept", {16'h0, d}, 32'h7777);
    wr(3'd1, 16'd40); runCmd(8'h01, s, n);
    rd(3'd2, d); chk("R9 user erased", {16'h0, d}, 32'hFFFF);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule